// File: doc/BRIEF.md
# Bipolar return-to-zero word transmitter with load queue

This block accepts 31-bit data words from a host, queues up to eight of them, and sends them one after another as a serial stream in the ARINC 429 electrical style. The stream uses two outputs in bipolar return-to-zero form. The host writes each word as two 16-bit halves. It strobes the lower half first and the upper half second. Only the second strobe commits the word to the queue.

When the enable input is high, the serializer takes the oldest queued word and appends a parity bit whose sense is chosen at run time. It shifts the 32 bits out least significant first. Each bit is a timed data phase followed by a null phase, and a fixed inter-word gap follows each word. Two speeds are supported. The speed and the parity sense are taken from their inputs at the moment a word starts. A ready flag tells the host when everything it loaded has been sent. A loopback control steers the stream away from the line outputs onto a pair of tap outputs that feed an on-chip receiver.

Top module: `bprz_word_tx`

## Requirements
- R1: During and after reset the queue is empty, `tx_ready` is 1 and all four stream outputs (`line_p`, `line_n`, `tap_p`, `tap_n`) are 0.
- R2: A strobe on `ld_lo` stores `ld_data` as bits 15..0 of a pending word. A later strobe on `ld_hi` supplies bits 30..16 from `ld_data[14:0]` and commits the word. `ld_data[15]` on the second half is discarded. A new `ld_lo` before `ld_hi` replaces the pending lower half. An `ld_hi` with no pending lower half is ignored. A cycle with both strobes high is ignored.
- R3: The queue holds 8 words and sends them in load order. A word committed while 8 words are queued is dropped and never sent.
- R4: With `tx_en` high and a word queued while the serializer is idle, the first data phase is on the outputs in the clock cycle right after the edge that sees this.
- R5: With `fast_sel` = 1 at word start, each bit is a 5-cycle data phase followed by a 5-cycle null phase. After the last null phase comes a 40-cycle gap.
- R6: With `fast_sel` = 0 at word start, each bit is a 40-cycle data phase and a 40-cycle null phase, and the gap is 320 cycles.
- R7: `fast_sel` and `par_even` are sampled only when a word starts. Changing them mid-word does not alter that word's timing or parity.
- R8: Bits go out in the order data bit 0 to data bit 30, then the parity bit as bit 31. The parity bit makes the count of ones among the 32 bits odd when `par_even` = 0 and even when `par_even` = 1.
- R9: During a data phase a 1 drives the positive output high and a 0 drives the negative output high. Both outputs are low in null phases, gaps and idle, and they are never high together.
- R10: `tx_ready` is 1 exactly when the queue is empty and no word or gap is in progress. After the last word it rises on the first cycle after the gap ends.
- R11: If `tx_en` is low at a clock edge, the serializer goes idle and all outputs are low from the next cycle. A word cut off this way is lost, and the next enable starts the next queued word.
- R12: With `lpbk_n` = 0 the stream appears on `tap_p`/`tap_n` and the line outputs stay low. With `lpbk_n` = 1 the stream appears on `line_p`/`line_n` and the tap outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is the timing unit of all phases |
| rst | input | 1 | Synchronous active-high reset |
| ld_lo | input | 1 | Strobe: capture lower half of a word |
| ld_hi | input | 1 | Strobe: capture upper half and commit the word |
| ld_data | input | 16 | Half-word data for either strobe |
| tx_en | input | 1 | Transmit enable |
| fast_sel | input | 1 | 1 = high speed, 0 = low speed |
| par_even | input | 1 | 0 = odd word parity, 1 = even word parity |
| lpbk_n | input | 1 | 0 = route stream to tap outputs |
| line_p | output | 1 | Positive line output |
| line_n | output | 1 | Negative line output |
| tap_p | output | 1 | Positive loopback tap to receiver |
| tap_n | output | 1 | Negative loopback tap to receiver |
| tx_ready | output | 1 | Queue empty and serializer idle |

## Verification
A corrupted queue pointer or level shows at the ports as a word out of order, repeated or missing. This is visible at the latest when the affected word is decoded, which is one word slot (360 or 2880 cycles) after it should have started. A bit counter or phase counter off by one shows within the first bit as a data or null phase of the wrong length, or as a gap of the wrong length after the word. A wrong parity sense or a wrong latching point shows as a bad bit 31 at the end of the word. A `tx_ready` that ignores the serializer or the gap rises early, and the bench measures its rise to the exact cycle after the last data phase.

// File: rtl/bprz_pkg.sv
package bprz_pkg;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_MARK  = 2'd1,
        SER_SPACE = 2'd2,
        SER_GAP   = 2'd3
    } ser_state_e;

    // Returns the bit that completes the word to odd (even=0) or even (even=1) parity.
    function automatic logic parity_bit(input logic [30:0] w, input logic even);
        return (^w) ^ ~even;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bprz_loader.sv
module bprz_loader #(
    parameter int HALF_W = 16,
    parameter int WORD_W = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [HALF_W-1:0] ld_data,
    output logic              push,
    output logic [WORD_W-1:0] push_word
);
    localparam int UPPER_W = WORD_W - HALF_W;

    logic [HALF_W-1:0] lo_q;
    logic              lo_pend;
    logic              lo_only;
    logic              hi_only;

    assign lo_only = ld_lo && !ld_hi;
    assign hi_only = ld_hi && !ld_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q    <= '0;
            lo_pend <= 1'b0;
        end else if (lo_only) begin
            lo_q    <= ld_data;
            lo_pend <= 1'b1;
        end else if (hi_only && lo_pend) begin
            lo_pend <= 1'b0;
        end
    end

    assign push      = hi_only && lo_pend;
    assign push_word = {ld_data[UPPER_W-1:0], lo_q};

endmodule

// File: rtl/bprz_fifo.sv
module bprz_fifo #(
    parameter int WIDTH = 31,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       pop,
    output logic [WIDTH-1:0]           rdata,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign do_push = push && (level != FULL);
    assign do_pop  = pop && (level != '0);
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/bprz_serializer.sv
module bprz_serializer
    import bprz_pkg::*;
#(
    parameter int WORD_W     = 31,
    parameter int HS_HALF    = 5,
    parameter int LS_HALF    = 40,
    parameter int GAP_HALVES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              fast_sel,
    input  logic              par_even,
    input  logic              have_word,
    input  logic [WORD_W-1:0] word_in,
    output logic              pop,
    output logic              mark_p,
    output logic              mark_n,
    output logic              busy
);
    localparam int HS_GAP = GAP_HALVES * HS_HALF;
    localparam int LS_GAP = GAP_HALVES * LS_HALF;
    localparam int CNT_W  = $clog2(max2(max2(HS_HALF, LS_HALF), max2(HS_GAP, LS_GAP)) + 1);
    localparam int BIT_W  = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] HS_T  = CNT_W'(HS_HALF - 1);
    localparam logic [CNT_W-1:0] LS_T  = CNT_W'(LS_HALF - 1);
    localparam logic [CNT_W-1:0] HSG_T = CNT_W'(HS_GAP - 1);
    localparam logic [CNT_W-1:0] LSG_T = CNT_W'(LS_GAP - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W);

    ser_state_e        state;
    logic [WORD_W:0]   sh;
    logic [BIT_W-1:0]  bit_idx;
    logic [CNT_W-1:0]  tcnt;
    logic              fast_q;
    logic              start;
    logic              tick;
    logic [CNT_W-1:0]  half_t;
    logic [CNT_W-1:0]  gap_t;

    assign tick   = (tcnt == '0);
    assign half_t = fast_q ? HS_T : LS_T;
    assign gap_t  = fast_q ? HSG_T : LSG_T;
    assign start  = tx_en && have_word &&
                    ((state == SER_IDLE) || ((state == SER_GAP) && tick));
    assign pop    = start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SER_IDLE;
            sh      <= '0;
            bit_idx <= '0;
            tcnt    <= '0;
            fast_q  <= 1'b0;
        end else if (!tx_en) begin
            state <= SER_IDLE;
            tcnt  <= '0;
        end else if (start) begin
            sh      <= {parity_bit(word_in, par_even), word_in};
            fast_q  <= fast_sel;
            bit_idx <= '0;
            tcnt    <= fast_sel ? HS_T : LS_T;
            state   <= SER_MARK;
        end else begin
            unique case (state)
                SER_MARK: begin
                    if (tick) begin
                        state <= SER_SPACE;
                        tcnt  <= half_t;
                    end else begin
                        tcnt <= tcnt - 1'b1;
                    end
                end
                SER_SPACE: begin
                    if (!tick) begin
                        tcnt <= tcnt - 1'b1;
                    end else if (bit_idx == LAST_BIT) begin
                        state <= SER_GAP;
                        tcnt  <= gap_t;
                    end else begin
                        state   <= SER_MARK;
                        sh      <= sh >> 1;
                        bit_idx <= bit_idx + 1'b1;
                        tcnt    <= half_t;
                    end
                end
                SER_GAP: begin
                    if (tick) state <= SER_IDLE;
                    else      tcnt  <= tcnt - 1'b1;
                end
                default: state <= SER_IDLE;
            endcase
        end
    end

    assign mark_p = (state == SER_MARK) && sh[0];
    assign mark_n = (state == SER_MARK) && !sh[0];
    assign busy   = (state != SER_IDLE);

endmodule

// File: rtl/bprz_word_tx.sv
module bprz_word_tx #(
    parameter int HALF_W     = 16,
    parameter int WORD_W     = 31,
    parameter int DEPTH      = 8,
    parameter int HS_HALF    = 5,
    parameter int LS_HALF    = 40,
    parameter int GAP_HALVES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [HALF_W-1:0] ld_data,
    input  logic              tx_en,
    input  logic              fast_sel,
    input  logic              par_even,
    input  logic              lpbk_n,
    output logic              line_p,
    output logic              line_n,
    output logic              tap_p,
    output logic              tap_n,
    output logic              tx_ready
);
    localparam int CW = $clog2(DEPTH + 1);

    logic              push;
    logic [WORD_W-1:0] push_word;
    logic              pop;
    logic [WORD_W-1:0] head_word;
    logic [CW-1:0]     fifo_level;
    logic              mark_p;
    logic              mark_n;
    logic              busy;

    bprz_loader #(.HALF_W(HALF_W), .WORD_W(WORD_W)) u_loader (
        .clk(clk), .rst(rst), .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_data(ld_data),
        .push(push), .push_word(push_word)
    );

    bprz_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .wdata(push_word),
        .pop(pop), .rdata(head_word), .level(fifo_level)
    );

    bprz_serializer #(
        .WORD_W(WORD_W), .HS_HALF(HS_HALF), .LS_HALF(LS_HALF), .GAP_HALVES(GAP_HALVES)
    ) u_ser (
        .clk(clk), .rst(rst), .tx_en(tx_en), .fast_sel(fast_sel), .par_even(par_even),
        .have_word(fifo_level != '0), .word_in(head_word), .pop(pop),
        .mark_p(mark_p), .mark_n(mark_n), .busy(busy)
    );

    assign line_p   = lpbk_n && mark_p;
    assign line_n   = lpbk_n && mark_n;
    assign tap_p    = !lpbk_n && mark_p;
    assign tap_n    = !lpbk_n && mark_n;
    assign tx_ready = (fifo_level == '0) && !busy;

endmodule

// File: rtl/bprz_word_tx_chk.sv
module bprz_word_tx_chk #(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       tx_en,
    input logic                       lpbk_n,
    input logic                       line_p,
    input logic                       line_n,
    input logic                       tap_p,
    input logic                       tap_n,
    input logic                       tx_ready,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level
);
    a_r9_never_both_high: assert property (@(posedge clk) disable iff (rst)
        !(line_p && line_n) && !(tap_p && tap_n));

    a_r12_line_quiet_in_loopback: assert property (@(posedge clk) disable iff (rst)
        !lpbk_n |-> (!line_p && !line_n));

    a_r12_tap_quiet_in_normal: assert property (@(posedge clk) disable iff (rst)
        lpbk_n |-> (!tap_p && !tap_n));

    a_r11_disable_goes_quiet: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (!line_p && !line_n && !tap_p && !tap_n));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= DEPTH);

    a_r3_level_single_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (fifo_level == $past(fifo_level) ||
                         fifo_level == $past(fifo_level) + 1'b1 ||
                         fifo_level + 1'b1 == $past(fifo_level)));

    a_r10_ready_means_quiet_and_empty: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (fifo_level == '0 && !line_p && !line_n && !tap_p && !tap_n));

endmodule

bind bprz_word_tx bprz_word_tx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .tx_en(tx_en), .lpbk_n(lpbk_n),
    .line_p(line_p), .line_n(line_n), .tap_p(tap_p), .tap_n(tap_n),
    .tx_ready(tx_ready), .fifo_level(fifo_level)
);

// File: tb/tb_bprz_word_tx.sv
module tb_bprz_word_tx;
    localparam int HS = 5;
    localparam int LS = 40;
    localparam int HS_GAP = 40;
    localparam int LS_GAP = 320;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_lo = 1'b0;
    logic        ld_hi = 1'b0;
    logic [15:0] ld_data = '0;
    logic        tx_en = 1'b0;
    logic        fast_sel = 1'b1;
    logic        par_even = 1'b0;
    logic        lpbk_n = 1'b1;
    logic        line_p, line_n, tap_p, tap_n, tx_ready;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  mon_tap = 1'b0;
    bit  done    = 1'b0;
    int  line_seen_in_loop = 0;

    always #2 clk = ~clk;

    bprz_word_tx dut (
        .clk(clk), .rst(rst), .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_data(ld_data),
        .tx_en(tx_en), .fast_sel(fast_sel), .par_even(par_even), .lpbk_n(lpbk_n),
        .line_p(line_p), .line_n(line_n), .tap_p(tap_p), .tap_n(tap_n),
        .tx_ready(tx_ready)
    );

    always @(negedge clk) if (!rst && !lpbk_n && (line_p || line_n)) line_seen_in_loop++;

    function automatic bit mon_active();
        return mon_tap ? (tap_p || tap_n) : (line_p || line_n);
    endfunction

    function automatic bit mon_bit();
        return mon_tap ? tap_p : line_p;
    endfunction

    function automatic logic [31:0] expect_word(input logic [30:0] w, input bit even);
        bit odd_ones;
        odd_ones = ($countones(w) % 2) == 1;
        return {even ? odd_ones : !odd_ones, w};
    endfunction

    task automatic check(input bit cond, input string req, input string what,
                         input longint actual, input longint expected);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
        end
    endtask

    task automatic load_word(input logic [30:0] w, input logic junk);
        @(negedge clk); ld_data = w[15:0]; ld_lo = 1'b1;
        @(negedge clk); ld_lo = 1'b0; ld_hi = 1'b1; ld_data = {junk, w[30:16]};
        @(negedge clk); ld_hi = 1'b0;
    endtask

    // Decodes one word from the monitored pair; returns with the first low sample after the last data phase current.
    task automatic get_word(input int half, input bit flip, output logic [31:0] w, output int bad);
        int guard;
        guard = 0; bad = 0; w = '0;
        while (!mon_active() && guard < 5000) begin @(negedge clk); guard++; end
        for (int i = 0; i < 32; i++) begin
            int d;
            int l;
            logic b;
            d = 0; l = 0;
            if (flip && i == 4) begin fast_sel = ~fast_sel; par_even = ~par_even; end
            b = mon_bit();
            while (mon_active() && d < half + 3) begin
                if (mon_bit() != b) bad++;
                d++;
                @(negedge clk);
            end
            w[i] = b;
            if (d != half) bad++;
            if (i < 31) begin
                while (!mon_active() && l < half + 3) begin l++; @(negedge clk); end
                if (l != half) bad++;
            end
        end
    endtask

    task automatic count_gap(output int n);
        n = 1;
        forever begin
            @(negedge clk);
            if (mon_active() || n > 2000) break;
            n++;
        end
    endtask

    task automatic wait_ready(output int n);
        n = 1;
        while (!tx_ready && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset();
        check(tx_ready == 1'b1, "R1", "ready after reset", tx_ready, 1);
        check({line_p, line_n, tap_p, tap_n} == 4'b0, "R1", "outputs after reset",
              {line_p, line_n, tap_p, tap_n}, 0);
    endtask

    task automatic t_high_speed_odd();
        logic [31:0] got; int bad; int n;
        fast_sel = 1'b1; par_even = 1'b0;
        load_word(31'h2A5C3E91, 1'b0);
        check(tx_ready == 1'b0, "R10", "ready low with word queued", tx_ready, 0);
        tx_en = 1'b1;
        @(negedge clk);
        check(line_p || line_n, "R4", "first data phase one cycle after enable", line_p | line_n, 1);
        get_word(HS, 1'b0, got, bad);
        check(got == expect_word(31'h2A5C3E91, 1'b0), "R8", "odd parity word", got, expect_word(31'h2A5C3E91, 1'b0));
        check(bad == 0, "R5", "high speed bit timing errors", bad, 0);
        wait_ready(n);
        check(n == HS + HS_GAP + 1, "R10", "ready rise after last word", n, HS + HS_GAP + 1);
        tx_en = 1'b0;
    endtask

    task automatic t_low_speed_even_latched();
        logic [31:0] got; int bad; int n;
        fast_sel = 1'b0; par_even = 1'b1;
        load_word(31'h0137_BEEF, 1'b0);
        tx_en = 1'b1;
        @(negedge clk);
        get_word(LS, 1'b1, got, bad);
        check(got == expect_word(31'h0137_BEEF, 1'b1), "R7", "even parity kept after mid-word flip",
              got, expect_word(31'h0137_BEEF, 1'b1));
        check(bad == 0, "R6", "low speed timing with mid-word speed flip", bad, 0);
        wait_ready(n);
        check(n == LS + LS_GAP + 1, "R6", "low speed gap then ready", n, LS + LS_GAP + 1);
        tx_en = 1'b0; fast_sel = 1'b1; par_even = 1'b0;
    endtask

    task automatic t_fifo_order();
        logic [30:0] ws [3];
        logic [31:0] got; int bad; int n;
        ws[0] = 31'h0000_0001; ws[1] = 31'h7FFF_FFFF; ws[2] = 31'h1234_5678;
        for (int i = 0; i < 3; i++) load_word(ws[i], 1'b0);
        tx_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            get_word(HS, 1'b0, got, bad);
            check(got == expect_word(ws[i], 1'b0), "R3", "word order", got, expect_word(ws[i], 1'b0));
            check(bad == 0, "R9", "rz encoding and phases", bad, 0);
            if (i < 2) begin
                count_gap(n);
                check(n == HS + HS_GAP, "R5", "low time between words", n, HS + HS_GAP);
            end
        end
        wait_ready(n);
        check(n == HS + HS_GAP + 1, "R10", "ready after three words", n, HS + HS_GAP + 1);
        tx_en = 1'b0;
    endtask

    task automatic t_full_drop();
        logic [31:0] got; int bad; int n; int quiet;
        for (int i = 0; i < 9; i++) load_word(31'(32'h0101_0000 * (i + 1) + i), 1'b0);
        tx_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            logic [30:0] w;
            w = 31'(32'h0101_0000 * (i + 1) + i);
            get_word(HS, 1'b0, got, bad);
            check(got == expect_word(w, 1'b0) && bad == 0, "R3", "queued word when filled",
                  got, expect_word(w, 1'b0));
        end
        wait_ready(n);
        check(n == HS + HS_GAP + 1, "R3", "ready after 8 words, ninth dropped", n, HS + HS_GAP + 1);
        quiet = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (line_p || line_n) quiet++; end
        check(quiet == 0, "R3", "no ninth word", quiet, 0);
        tx_en = 1'b0;
    endtask

    task automatic t_strobes();
        logic [31:0] got; int bad; int n;
        @(negedge clk); ld_data = 16'h1234; ld_hi = 1'b1;
        @(negedge clk); ld_hi = 1'b0;
        @(negedge clk);
        check(tx_ready == 1'b1, "R2", "upper half alone ignored", tx_ready, 1);
        ld_lo = 1'b1; ld_hi = 1'b1; ld_data = 16'h5555;
        @(negedge clk); ld_lo = 1'b0; ld_hi = 1'b0;
        @(negedge clk);
        check(tx_ready == 1'b1, "R2", "both strobes together ignored", tx_ready, 1);
        ld_lo = 1'b1; ld_data = 16'hAAAA;
        @(negedge clk); ld_data = 16'h0F0F;
        @(negedge clk); ld_lo = 1'b0; ld_hi = 1'b1; ld_data = 16'hC321;
        @(negedge clk); ld_hi = 1'b0;
        tx_en = 1'b1;
        get_word(HS, 1'b0, got, bad);
        check(got == expect_word(31'h4321_0F0F, 1'b0), "R2", "halves joined, bit 15 of upper discarded",
              got, expect_word(31'h4321_0F0F, 1'b0));
        wait_ready(n);
        tx_en = 1'b0;
    endtask

    task automatic t_abort();
        logic [31:0] got; int bad; int n; int noisy;
        load_word(31'h0AAA_5555, 1'b0);
        load_word(31'h3C3C_C3C3, 1'b0);
        tx_en = 1'b1;
        repeat (50) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        check(!(line_p || line_n), "R11", "quiet the cycle after disable", line_p | line_n, 0);
        check(tx_ready == 1'b0, "R11", "second word still queued", tx_ready, 0);
        noisy = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (line_p || line_n) noisy++; end
        check(noisy == 0, "R11", "stays quiet while disabled", noisy, 0);
        tx_en = 1'b1;
        @(negedge clk);
        get_word(HS, 1'b0, got, bad);
        check(got == expect_word(31'h3C3C_C3C3, 1'b0), "R11", "next word after aborted one",
              got, expect_word(31'h3C3C_C3C3, 1'b0));
        wait_ready(n);
        tx_en = 1'b0;
    endtask

    task automatic t_loopback();
        logic [31:0] got; int bad; int n;
        lpbk_n = 1'b0; mon_tap = 1'b1; line_seen_in_loop = 0;
        load_word(31'h5A5A_1234, 1'b0);
        tx_en = 1'b1;
        get_word(HS, 1'b0, got, bad);
        check(got == expect_word(31'h5A5A_1234, 1'b0) && bad == 0, "R12", "word on tap outputs",
              got, expect_word(31'h5A5A_1234, 1'b0));
        wait_ready(n);
        check(line_seen_in_loop == 0, "R12", "line quiet in loopback", line_seen_in_loop, 0);
        tx_en = 1'b0;
        @(negedge clk);
        lpbk_n = 1'b1; mon_tap = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_high_speed_odd();
        t_low_speed_even_latched();
        t_fifo_order();
        t_full_drop();
        t_strobes();
        t_abort();
        t_loopback();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule